// File: doc/BRIEF.md
# Sequenced ADC Conversion Controller

This block runs the conversion sequence for an eight-input multiplexed analog-to-digital converter. The host reaches it over a 16-bit register bus with 4-bit addresses. One control register powers the converter and picks the input. The same register can choose an external reference, connect the reference bypass, and hold the conversion until an external sync pulse arrives. Writing its start bit launches a conversion.

After power-on the block waits for the reference to settle. It then spends a fixed input-select interval and a fixed conversion interval. At the end it captures the converter's 10-bit code into a data register with a valid flag, and pulses the completion interrupt source (source 11 in the interrupt map). The analog converter is outside the block. The code it would produce arrives on a sample input.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, reads of the control register (address 0xA) and of the data register (address 0xB) return 0, and `adcOn` and `convDone` are low.
- R2: A write to address 0xA stores these control bits, each of which reads back at the same position (all other bits read 0):
  - bit 15: power-on
  - bit 7: start
  - bit 5: external reference
  - bits 4:2: input code (0–3 touch lines, 4–7 auxiliary)
  - bit 1: bypass
  - bit 0: sync wait

  `adcOn`, `muxSel`, `extRefSel` and `refBypass` follow the stored bits.
- R3: When a single write sets bits 15 and 7 together from the off state, `convDone` pulses exactly SETTLE_CYC+SEL_CYC+CONV_CYC+1 cycles after the write edge. The extra cycle is the one spent registering the power-on bit.
- R4: A conversion starts only when bit 7 goes from 0 to 1 in a write that also has bit 15 set. Writing again with bit 7 already 1 during a conversion neither restarts it nor moves its completion.
- R5: On completion, address 0xB reads bit 15 = 1 and bits 14:5 = the `sampleIn` code present at the completing edge; all other bits read 0.
- R6: `convDone` is high for exactly one cycle per completed conversion.
- R7: Once powered and settled, a start completes SEL_CYC+CONV_CYC cycles after the write edge. The valid flag (bit 15 of 0xB) reads 0 from the edge that starts the conversion.
- R8: With bit 0 set, the conversion phase does not begin while `syncIn` is low. `convDone` pulses CONV_CYC cycles after the edge at which `syncIn` is first seen high after the select interval.
- R9: Clearing bit 15 aborts a conversion in progress. No `convDone` follows, the valid flag reads 0, and a later power-on runs the settle interval again.
- R10: Without sync wait, a conversion finishes within 256 bus clock cycles (two 128-bit frames) of its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 4 | Register address for reads and writes |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data of the addressed register (combinational) |
| syncIn | input | 1 | External conversion trigger |
| sampleIn | input | 10 | Code from the analog converter |
| adcOn | output | 1 | Converter power-on |
| muxSel | output | 3 | Selected input |
| extRefSel | output | 1 | External reference select |
| refBypass | output | 1 | Reference bypass connect |
| convDone | output | 1 | Completion interrupt source pulse |

## Verification
The bench builds the block with SETTLE_CYC reduced to 12 and keeps the select and conversion lengths at their defaults of 51 and 102. The real 153-cycle no-sync path is therefore measured against the 256-cycle two-frame limit. The short settle lets power-on, abort and re-power sequences fit alongside a run of random input, reference and sample values. The sync gate is held closed for several hundred cycles before it is released.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_SETTLE, S_READY, S_SELECT, S_WAITSYNC, S_CONVERT
  } seqState_t;

  typedef struct packed {
    logic loadResult;
    logic clearValid;
  } seqStrobe_t;

  localparam int BIT_EN     = 15;
  localparam int BIT_START  = 7;
  localparam int BIT_EXTREF = 5;
  localparam int BIT_SELLO  = 2;
  localparam int BIT_BYPASS = 1;
  localparam int BIT_SYNC   = 0;
  localparam int BIT_VALID  = 15;
  localparam int BIT_RESLO  = 5;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int RES_W = 10,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 4'hA,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 4'hB
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [RES_W-1:0]  sampleIn,
  input  seqStrobe_t        strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              enQ,
  output logic              syncEnQ,
  output logic              startRise,
  output logic [2:0]        selQ,
  output logic              extRefQ,
  output logic              bypassQ,
  output logic              validQ
);
  logic             startQ;
  logic [RES_W-1:0] resultQ;
  logic             wrCtrl;

  assign wrCtrl    = wrEn && (addr == CTRL_ADDR);
  assign startRise = wrCtrl && wrData[BIT_EN] && wrData[BIT_START] && !startQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ <= 1'b0; startQ <= 1'b0; extRefQ <= 1'b0;
      selQ <= '0; bypassQ <= 1'b0; syncEnQ <= 1'b0;
    end else if (wrCtrl) begin
      enQ     <= wrData[BIT_EN];
      startQ  <= wrData[BIT_START];
      extRefQ <= wrData[BIT_EXTREF];
      selQ    <= wrData[BIT_SELLO +: 3];
      bypassQ <= wrData[BIT_BYPASS];
      syncEnQ <= wrData[BIT_SYNC];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ  <= 1'b0;
      resultQ <= '0;
    end else if (strobe.loadResult) begin
      validQ  <= 1'b1;
      resultQ <= sampleIn;
    end else if (strobe.clearValid) begin
      validQ  <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == CTRL_ADDR) begin
      rdData[BIT_EN]          = enQ;
      rdData[BIT_START]       = startQ;
      rdData[BIT_EXTREF]      = extRefQ;
      rdData[BIT_SELLO +: 3]  = selQ;
      rdData[BIT_BYPASS]      = bypassQ;
      rdData[BIT_SYNC]        = syncEnQ;
    end else if (addr == DATA_ADDR) begin
      rdData[BIT_VALID]           = validQ;
      rdData[BIT_RESLO +: RES_W]  = resultQ;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 60,
  parameter int SEL_CYC = 51,
  parameter int CONV_CYC = 102
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       enQ,
  input  logic       syncEnQ,
  input  logic       startRise,
  input  logic       syncIn,
  output seqState_t  seqState,
  output seqStrobe_t strobe,
  output logic       convDone
);
  localparam int MAX_AB = (SETTLE_CYC > SEL_CYC) ? SETTLE_CYC : SEL_CYC;
  localparam int MAX_LEN = (MAX_AB > CONV_CYC) ? MAX_AB : CONV_CYC;
  localparam int CNT_W = $clog2(MAX_LEN + 1);

  seqState_t  nxtState;
  logic [CNT_W-1:0] phaseCnt;
  logic       pending;
  logic       busy;
  logic       accept;

  assign busy   = (seqState == S_SELECT) || (seqState == S_WAITSYNC) || (seqState == S_CONVERT);
  assign accept = (nxtState == S_SELECT) && (seqState != S_SELECT);

  always_comb begin
    nxtState = seqState;
    strobe   = '0;
    if (!enQ) begin
      nxtState = S_IDLE;
      strobe.clearValid = 1'b1;
    end else begin
      case (seqState)
        S_IDLE:   nxtState = S_SETTLE;
        S_SETTLE: if (phaseCnt == CNT_W'(SETTLE_CYC - 1))
                    nxtState = (pending || startRise) ? S_SELECT : S_READY;
        S_READY:  if (pending || startRise) nxtState = S_SELECT;
        S_SELECT: if (phaseCnt == CNT_W'(SEL_CYC - 1))
                    nxtState = syncEnQ ? S_WAITSYNC : S_CONVERT;
        S_WAITSYNC: if (syncIn) nxtState = S_CONVERT;
        S_CONVERT: if (phaseCnt == CNT_W'(CONV_CYC - 1)) begin
                    nxtState = S_READY;
                    strobe.loadResult = 1'b1;
                  end
        default:  nxtState = S_IDLE;
      endcase
      if (accept) strobe.clearValid = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      seqState <= S_IDLE;
      phaseCnt <= '0;
      pending  <= 1'b0;
      convDone <= 1'b0;
    end else begin
      seqState <= nxtState;
      phaseCnt <= (nxtState != seqState) ? '0 : phaseCnt + 1'b1;
      convDone <= strobe.loadResult;
      if (accept)                  pending <= 1'b0;
      else if (startRise && !busy) pending <= 1'b1;
      else if (!enQ)               pending <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 60,
  parameter int SEL_CYC = 51,
  parameter int CONV_CYC = 102,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 4,
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              syncIn,
  input  logic [RES_W-1:0]  sampleIn,
  output logic              adcOn,
  output logic [2:0]        muxSel,
  output logic              extRefSel,
  output logic              refBypass,
  output logic              convDone
);
  seqStrobe_t strobe;
  seqState_t  seqState;
  logic       syncEnQ;
  logic       startRise;
  logic       validQ;

  adc_seq_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RES_W(RES_W)
  ) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(busWrEn), .addr(busAddr), .wrData(busWrData),
    .sampleIn(sampleIn), .strobe(strobe), .rdData(busRdData), .enQ(adcOn),
    .syncEnQ(syncEnQ), .startRise(startRise), .selQ(muxSel), .extRefQ(extRefSel),
    .bypassQ(refBypass), .validQ(validQ)
  );

  adc_seq_ctrl #(
    .SETTLE_CYC(SETTLE_CYC), .SEL_CYC(SEL_CYC), .CONV_CYC(CONV_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .enQ(adcOn), .syncEnQ(syncEnQ), .startRise(startRise),
    .syncIn(syncIn), .seqState(seqState), .strobe(strobe), .convDone(convDone)
  );
endmodule

// File: rtl/adc_conv_seq_chk.sv
module adc_conv_seq_chk
  import adc_seq_pkg::*;
#(
  parameter int FRAME_LIMIT = 256
) (
  input logic      clk,
  input logic      rstN,
  input seqState_t seqState,
  input logic      syncIn,
  input logic      syncEnQ,
  input logic      adcOn,
  input logic      validQ,
  input logic      convDone
);
  logic [15:0] runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (!syncEnQ && (seqState == S_SELECT || seqState == S_CONVERT)) runCnt <= runCnt + 16'd1;
    else runCnt <= '0;
  end

  // R6: completion pulse lasts one cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

  // R5: valid rises only together with the completion pulse
  p_valid_with_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> convDone);

  // R9: power-off returns to idle and drops valid
  p_off_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    !adcOn |=> (seqState == S_IDLE) && !validQ);

  // R8: conversion phase is gated by the sync input
  p_sync_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seqState == S_WAITSYNC && !syncIn) |=> seqState != S_CONVERT);

  // R10: no-sync conversion stays within two frames
  p_two_frames_r10: assert property (@(posedge clk) disable iff (!rstN)
    runCnt < 16'(FRAME_LIMIT));
endmodule

bind adc_conv_seq adc_conv_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .seqState(seqState), .syncIn(syncIn), .syncEnQ(syncEnQ),
  .adcOn(adcOn), .validQ(validQ), .convDone(convDone)
);

// File: tb/adc_conv_seq_tb.sv
module adc_conv_seq_tb;
  localparam int SETTLE = 12;
  localparam int SEL = 51;
  localparam int CONV = 102;
  localparam logic [3:0] A_CTRL = 4'hA;
  localparam logic [3:0] A_DATA = 4'hB;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWrEn = 1'b0;
  logic [3:0] busAddr = A_DATA;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic syncIn = 1'b0;
  logic [9:0] sampleIn = '0;
  logic adcOn, extRefSel, refBypass, convDone;
  logic [2:0] muxSel;

  int vectors = 0;
  int misses = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  adc_conv_seq #(.SETTLE_CYC(SETTLE), .SEL_CYC(SEL), .CONV_CYC(CONV)) u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .syncIn(syncIn), .sampleIn(sampleIn), .adcOn(adcOn),
    .muxSel(muxSel), .extRefSel(extRefSel), .refBypass(refBypass), .convDone(convDone)
  );

  function automatic logic [15:0] ctrlWord(bit en, bit st, bit ext, logic [2:0] sel, bit byp, bit sy);
    return {en, 7'b0, st, 1'b0, ext, sel, byp, sy};
  endfunction

  function automatic logic [15:0] dataWord(bit v, logic [9:0] code);
    return {v, code, 5'b0};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = A_CTRL; busWrData = d;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = A_DATA;
  endtask

  task automatic waitDone(output int n);
    n = 0;
    for (int i = 1; i <= 600; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (convDone) begin n = i; return; end
    end
    n = -1;
  endtask

  task automatic noDoneFor(int cyc, output bit seen);
    seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (convDone) seen = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    int n, n2;
    bit seen;
    logic [9:0] code;
    logic [2:0] sel;
    bit ext, byp;
    void'($urandom(32'h5eed));

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    busAddr = A_CTRL; #1 check("R1 ctrl", busRdData, 0);
    busAddr = A_DATA; #1 check("R1 data", busRdData, 0);
    check("R1 adcOn", adcOn, 0);
    check("R1 convDone", convDone, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R4: start with power off does nothing
    wr(ctrlWord(0, 1, 0, 3'd2, 0, 0));
    noDoneFor(300, seen);
    check("R4 start while off", seen, 0);
    wr(ctrlWord(0, 0, 0, 3'd0, 0, 0));

    // R2: register fields and pins
    wr(ctrlWord(0, 0, 1, 3'd5, 1, 1));
    busAddr = A_CTRL; #1 check("R2 readback", busRdData, 16'h0037);
    busAddr = A_DATA;
    check("R2 pins", {adcOn, muxSel, extRefSel, refBypass}, {1'b0, 3'd5, 1'b1, 1'b1});
    wr(ctrlWord(0, 0, 0, 3'd0, 0, 0));

    // R3: power-on and start together
    sampleIn = 10'h2A5;
    wr(ctrlWord(1, 1, 0, 3'd6, 0, 0));
    waitDone(n);
    check("R3 latency from power-on", n, SETTLE + SEL + CONV + 1);
    #1 check("R5 data", busRdData, dataWord(1, 10'h2A5));
    @(negedge clk);
    check("R6 pulse width", convDone, 0);

    // R7: valid cleared at start, latency from ready
    wr(ctrlWord(1, 0, 0, 3'd6, 0, 0));
    #1 check("R7 valid kept by non-start write", busRdData[15], 1);
    sampleIn = 10'h111;
    wr(ctrlWord(1, 1, 0, 3'd1, 0, 0));
    #1 check("R7 valid cleared at start", busRdData[15], 0);
    waitDone(n);
    check("R7 latency from ready", n, SEL + CONV);
    check("R10 within two frames", (n > 0 && n <= 256), 1);

    // R4: rewrite with start held mid-conversion
    wr(ctrlWord(1, 0, 0, 3'd1, 0, 0));
    sampleIn = 10'h3C3;
    wr(ctrlWord(1, 1, 0, 3'd3, 0, 0));
    repeat (39) @(posedge clk);
    wr(ctrlWord(1, 1, 0, 3'd4, 0, 0));
    waitDone(n2);
    check("R4 no restart", 40 + n2, SEL + CONV);
    #1 check("R4 result", busRdData, dataWord(1, 10'h3C3));

    // R8: sync gate
    wr(ctrlWord(1, 0, 0, 3'd0, 0, 1));
    sampleIn = 10'h0F0;
    wr(ctrlWord(1, 1, 0, 3'd0, 0, 1));
    noDoneFor(400, seen);
    check("R8 held without sync", seen, 0);
    @(negedge clk);
    syncIn = 1'b1;
    @(posedge clk);
    n = 1;
    @(negedge clk);
    syncIn = 1'b0;
    if (convDone) n = -1;
    else begin
      waitDone(n2);
      n = (n2 < 0) ? -1 : n2 + 1;
    end
    check("R8 latency from sync", n, CONV + 1);
    #1 check("R8 result", busRdData, dataWord(1, 10'h0F0));

    // R9: abort by power-off
    wr(ctrlWord(1, 0, 0, 3'd0, 0, 0));
    wr(ctrlWord(1, 1, 0, 3'd0, 0, 0));
    repeat (50) @(posedge clk);
    wr(ctrlWord(0, 0, 0, 3'd0, 0, 0));
    noDoneFor(300, seen);
    check("R9 no done after abort", seen, 0);
    #1 check("R9 valid cleared", busRdData[15], 0);
    check("R9 adcOn low", adcOn, 0);
    sampleIn = 10'h055;
    wr(ctrlWord(1, 1, 0, 3'd7, 0, 0));
    waitDone(n);
    check("R9 settle rerun", n, SETTLE + SEL + CONV + 1);

    // random conversions
    for (int i = 0; i < 16; i++) begin
      sel = 3'($urandom % 8);
      ext = 1'($urandom);
      byp = 1'($urandom);
      code = 10'($urandom);
      sampleIn = code;
      wr(ctrlWord(1, 0, ext, sel, byp, 0));
      wr(ctrlWord(1, 1, ext, sel, byp, 0));
      check("R2 random pins", {adcOn, muxSel, extRefSel, refBypass}, {1'b1, sel, ext, byp});
      waitDone(n);
      check("R7 random latency", n, SEL + CONV);
      #1 check("R5 random data", busRdData, dataWord(1, code));
      @(negedge clk);
      check("R6 random pulse", convDone, 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule